// File: doc/BRIEF.md
# Bus Transaction Trace Recorder

This block sits beside a shared on-chip bus and turns its raw handshake into compact event records. A transaction opens when one master's request is granted, and it closes when the bus acknowledge names that master. Each opening yields a start record, and each closing yields an end record. A small table remembers one open transaction per master, so the end record carries the same slave, folded address, direction, command and tag as the start record it answers. Transactions that overlap stay distinguishable through their tags.

Records go into a circular buffer that runs without pause and overwrites its oldest entries once it fills. When the system fails or hangs, a freeze input stops further writes. Software then walks the buffer through an index port, and index 0 always returns the oldest surviving record. The current write pointer and a sticky wrapped flag are visible to software at all times.

Top module: `trc_bus_recorder`

## Requirements
- R1: After reset the write pointer is 0, the wrapped flag is 0 and no master has an open transaction, so an acknowledge arriving right after reset writes nothing.
- R2: A start record is written in the clock edge where `bus_req_i[m]` and `bus_gnt_i[m]` are both high. A request without a grant writes nothing.
- R3: The 15-bit record is laid out as follows: bit 14 is the kind (1 start, 0 end), bits 13:12 the master, bits 11:10 the slave, bits 9:6 the address fold (XOR of the four 4-bit nibbles of `bus_addr_i`), bit 5 the direction (1 write, 0 read), bits 4:3 the command and bits 2:0 the tag.
- R4: Tags are handed out per start, counting 0, 1, 2 and so on modulo 8 from reset, and tagging also continues while frozen.
- R5: An acknowledge for a master with an open transaction writes an end record that repeats that transaction's slave, fold, direction, command and tag with kind 0, and closes the transaction. An acknowledge for a master with nothing open writes nothing.
- R6: When a start and an end fall in the same cycle, the start record takes slot `wptr` and the end record takes slot `wptr+1`, and the pointer advances by 2. This also holds when both belong to the same master, and in that case the new transaction stays open.
- R7: The pointer wraps modulo 16. The wrapped flag rises when a write passes the last slot and stays high until reset. Once wrapped, new records overwrite the oldest.
- R8: Readout index `i` returns the i-th oldest stored record: the slot `i` before wrapping, and the slot `wptr+i` after it.
- R9: While `freeze_i` is high no record is written, and the pointer, the wrapped flag and the stored records stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 4 | Request line per master |
| bus_gnt_i | input | 4 | Grant per master, at most one high |
| bus_slv_i | input | 2 | Target slave of the granted request |
| bus_addr_i | input | 16 | Address of the granted request |
| bus_wr_i | input | 1 | Direction of the granted request, 1 write |
| bus_cmd_i | input | 2 | Command of the granted request |
| bus_ack_i | input | 1 | Transfer acknowledge |
| bus_ack_mst_i | input | 2 | Master that the acknowledge belongs to |
| freeze_i | input | 1 | Stops all buffer writes while high |
| rd_idx_i | input | 4 | Readout index counted from the oldest record |
| rd_data_o | output | 15 | Record at the requested index |
| wptr_o | output | 4 | Next slot to be written |
| wrapped_o | output | 1 | Sticky flag, buffer has wrapped |

## Verification
A granted request and an acknowledge can land on the same edge, and each then needs its own slot. The bench provokes this in two ways: once with the acknowledge closing a different master's transaction, and once with the acknowledge closing the very master that is being granted again. It judges the result by the pointer advancing by two, by the start record sitting below the end record in readout, and by a later acknowledge still finding the re-opened transaction with its new tag.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int MST_W = 2;
    localparam int SLV_W = 2;
    localparam int FLD_W = 4;
    localparam int CMD_W = 2;
    localparam int TAG_W = 3;
    localparam int NMST  = 1 << MST_W;

    typedef enum logic {
        EV_END   = 1'b0,
        EV_START = 1'b1
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e           kind;
        logic [MST_W-1:0]   mst;
        logic [SLV_W-1:0]   slv;
        logic [FLD_W-1:0]   fold;
        logic               wr;
        logic [CMD_W-1:0]   cmd;
        logic [TAG_W-1:0]   tag;
    } trc_rec_t;

    localparam int REC_W = $bits(trc_rec_t);

    // Index of the set bit of a vector with at most one bit high.
    function automatic logic [MST_W-1:0] onehot_idx(input logic [NMST-1:0] v);
        logic [MST_W-1:0] r;
        r = '0;
        for (int i = 0; i < NMST; i++) begin
            if (v[i]) r = r | MST_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/trc_addr_fold.sv
module trc_addr_fold
    import trc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [FLD_W-1:0]  fold_o
);
    localparam int NCHUNK = ADDR_W / FLD_W;

    logic [FLD_W-1:0] part [NCHUNK];

    genvar g;
    generate
        for (g = 0; g < NCHUNK; g++) begin : g_chunk
            if (g == 0) begin : g_first
                assign part[g] = addr_i[FLD_W-1:0];
            end else begin : g_next
                assign part[g] = part[g-1] ^ addr_i[g*FLD_W +: FLD_W];
            end
        end
    endgenerate

    assign fold_o = part[NCHUNK-1];
endmodule

// File: rtl/trc_event_detect.sv
module trc_event_detect
    import trc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NMST-1:0]  req_i,
    input  logic [NMST-1:0]  gnt_i,
    input  logic [SLV_W-1:0] slv_i,
    input  logic [FLD_W-1:0] fold_i,
    input  logic             wr_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             ack_i,
    input  logic [MST_W-1:0] ack_mst_i,
    output logic             st_fire_o,
    output trc_rec_t         st_rec_o,
    output logic             en_fire_o,
    output trc_rec_t         en_rec_o
);
    logic [NMST-1:0]  open_q;
    trc_rec_t         open_rec_q [NMST];
    logic [TAG_W-1:0] tag_q;
    logic [NMST-1:0]  hit;
    logic [MST_W-1:0] st_mst;

    always_comb begin
        hit       = req_i & gnt_i;
        st_mst    = onehot_idx(hit);
        st_fire_o = |hit;
        st_rec_o  = '{kind: EV_START, mst: st_mst, slv: slv_i, fold: fold_i,
                      wr: wr_i, cmd: cmd_i, tag: tag_q};
        en_fire_o = ack_i && open_q[ack_mst_i];
        en_rec_o      = open_rec_q[ack_mst_i];
        en_rec_o.kind = EV_END;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= '0;
            tag_q  <= '0;
            for (int i = 0; i < NMST; i++) open_rec_q[i] <= '0;
        end else begin
            // Close first so that a re-grant of the same master keeps it open.
            if (en_fire_o) open_q[ack_mst_i] <= 1'b0;
            if (st_fire_o) begin
                open_q[st_mst]     <= 1'b1;
                open_rec_q[st_mst] <= st_rec_o;
                tag_q              <= tag_q + TAG_W'(1);
            end
        end
    end
endmodule

// File: rtl/trc_ring.sv
module trc_ring
    import trc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frz_i,
    input  logic             v0_i,
    input  trc_rec_t         d0_i,
    input  logic             v1_i,
    input  trc_rec_t         d1_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output trc_rec_t         rd_data_o,
    output logic [PTR_W-1:0] wptr_o,
    output logic             wrapped_o
);
    trc_rec_t         mem [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic             wrapped_q;
    logic [PTR_W:0]   nxt;
    logic [PTR_W-1:0] base;

    always_comb begin
        nxt  = {1'b0, wptr_q} + (PTR_W+1)'(v0_i) + (PTR_W+1)'(v1_i);
        base = wrapped_q ? wptr_q : '0;
    end

    always_ff @(posedge clk) begin
        if (!frz_i) begin
            if (v0_i) mem[wptr_q] <= d0_i;
            if (v1_i) mem[wptr_q + PTR_W'(1)] <= d1_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q    <= '0;
            wrapped_q <= 1'b0;
        end else if (!frz_i) begin
            wptr_q <= nxt[PTR_W-1:0];
            if (nxt[PTR_W]) wrapped_q <= 1'b1;
        end
    end

    assign rd_data_o = mem[base + rd_idx_i];
    assign wptr_o    = wptr_q;
    assign wrapped_o = wrapped_q;
endmodule

// File: rtl/trc_bus_recorder.sv
module trc_bus_recorder
    import trc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NMST-1:0]   bus_req_i,
    input  logic [NMST-1:0]   bus_gnt_i,
    input  logic [SLV_W-1:0]  bus_slv_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [CMD_W-1:0]  bus_cmd_i,
    input  logic              bus_ack_i,
    input  logic [MST_W-1:0]  bus_ack_mst_i,
    input  logic              freeze_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [REC_W-1:0]  rd_data_o,
    output logic [PTR_W-1:0]  wptr_o,
    output logic              wrapped_o
);
    logic [FLD_W-1:0] fold;
    logic             st_fire, en_fire;
    trc_rec_t         st_rec, en_rec, slot0, rd_rec;

    trc_addr_fold #(.ADDR_W(ADDR_W)) u_fold (
        .addr_i (bus_addr_i),
        .fold_o (fold)
    );

    trc_event_detect u_det (
        .clk       (clk),
        .rst       (rst),
        .req_i     (bus_req_i),
        .gnt_i     (bus_gnt_i),
        .slv_i     (bus_slv_i),
        .fold_i    (fold),
        .wr_i      (bus_wr_i),
        .cmd_i     (bus_cmd_i),
        .ack_i     (bus_ack_i),
        .ack_mst_i (bus_ack_mst_i),
        .st_fire_o (st_fire),
        .st_rec_o  (st_rec),
        .en_fire_o (en_fire),
        .en_rec_o  (en_rec)
    );

    // Start record always takes the lower slot when both fire.
    assign slot0 = st_fire ? st_rec : en_rec;

    trc_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .frz_i     (freeze_i),
        .v0_i      (st_fire | en_fire),
        .d0_i      (slot0),
        .v1_i      (st_fire & en_fire),
        .d1_i      (en_rec),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_rec),
        .wptr_o    (wptr_o),
        .wrapped_o (wrapped_o)
    );

    assign rd_data_o = rd_rec;
endmodule

// File: rtl/trc_bus_recorder_chk.sv
module trc_bus_recorder_chk
    import trc_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             freeze_i,
    input logic [NMST-1:0]  bus_gnt_i,
    input logic             st_fire,
    input logic             en_fire,
    input logic [PTR_W-1:0] wptr_o,
    input logic             wrapped_o
);
    // R2: at most one grant at a time is what the start detector relies on.
    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_gnt_i));

    p_frozen_hold_r9: assert property (@(posedge clk) disable iff (rst)
        freeze_i |=> ($stable(wptr_o) && $stable(wrapped_o)));

    p_wrap_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        wrapped_o |=> wrapped_o);

    p_dual_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!freeze_i && st_fire && en_fire) |=> (wptr_o == ($past(wptr_o) + PTR_W'(2))));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!st_fire && !en_fire) |=> $stable(wptr_o));
endmodule

bind trc_bus_recorder trc_bus_recorder_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .freeze_i  (freeze_i),
    .bus_gnt_i (bus_gnt_i),
    .st_fire   (st_fire),
    .en_fire   (en_fire),
    .wptr_o    (wptr_o),
    .wrapped_o (wrapped_o)
);

// File: tb/tb_trc_bus_recorder.sv
`timescale 1ns/1ps
module tb_trc_bus_recorder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_req_i = '0, bus_gnt_i = '0;
    logic [1:0]  bus_slv_i = '0, bus_cmd_i = '0, bus_ack_mst_i = '0;
    logic [15:0] bus_addr_i = '0;
    logic        bus_wr_i = 1'b0, bus_ack_i = 1'b0, freeze_i = 1'b0;
    logic [3:0]  rd_idx_i = '0;
    logic [14:0] rd_data_o;
    logic [3:0]  wptr_o;
    logic        wrapped_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Bench-side expectation built from the requirements.
    logic [14:0] hist [64];
    int          total = 0;
    logic        op [4];
    logic [14:0] orec [4];
    logic [2:0]  tagc = '0;

    always #2.5 clk = ~clk;

    trc_bus_recorder dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] fold16(input logic [15:0] a);
        return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12];
    endfunction

    // One bus cycle; the expectation follows R2..R6 and R9.
    task automatic step(input string req, input logic sv, input logic [1:0] sm,
                        input logic [1:0] ss, input logic [15:0] sa, input logic sw,
                        input logic [1:0] sc, input logic av, input logic [1:0] am,
                        input logic frz);
        logic [14:0] rs, re;
        logic        ef;
        @(negedge clk);
        bus_req_i = sv ? (4'b1 << sm) : 4'b0;
        bus_gnt_i = bus_req_i;
        bus_slv_i = ss; bus_addr_i = sa; bus_wr_i = sw; bus_cmd_i = sc;
        bus_ack_i = av; bus_ack_mst_i = am; freeze_i = frz;
        rs = {1'b1, sm, ss, fold16(sa), sw, sc, tagc};
        ef = av && op[am];
        re = {1'b0, orec[am][13:0]};
        @(posedge clk);
        #1;
        if (!frz) begin
            if (sv) begin hist[total] = rs; total++; end
            if (ef) begin hist[total] = re; total++; end
        end
        if (ef) op[am] = 1'b0;
        if (sv) begin op[sm] = 1'b1; orec[sm] = rs; tagc = tagc + 3'd1; end
        chk({req, " wptr"}, 32'(wptr_o), 32'(total % 16));
        chk({req, " wrapped"}, 32'(wrapped_o), 32'(total >= 16));
        bus_req_i = '0; bus_gnt_i = '0; bus_ack_i = 1'b0;
    endtask

    task automatic read_at(input logic [3:0] i, output logic [14:0] v);
        rd_idx_i = i;
        #1;
        v = rd_data_o;
    endtask

    task automatic check_ring(input string req);
        int n;
        logic [14:0] v;
        n = (total < 16) ? total : 16;
        for (int i = 0; i < n; i++) begin
            read_at(4'(i), v);
            chk(req, 32'(v), 32'(hist[total - n + i]));
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin op[i] = 1'b0; orec[i] = '0; end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 reset wptr", 32'(wptr_o), 32'd0);
        chk("R1 reset wrapped", 32'(wrapped_o), 32'd0);
        step("R1 ack after reset", 0, 0, 0, 0, 0, 0, 1, 1, 0);
    endtask

    task automatic t_start_end;
        logic [14:0] v;
        step("R2 start m1", 1, 1, 2, 16'h003A, 1, 2, 0, 0, 0);
        read_at(4'd0, v);
        // R3: fold of 0x003A is 0xA ^ 0x3 = 0x9
        chk("R3 start layout", 32'(v), 32'({1'b1, 2'd1, 2'd2, 4'h9, 1'b1, 2'd2, 3'd0}));
        @(negedge clk); bus_req_i = 4'b0100; bus_gnt_i = 4'b0000;
        @(posedge clk); #1;
        chk("R2 request without grant", 32'(wptr_o), 32'd1);
        bus_req_i = '0;
        step("R5 end m1", 0, 0, 0, 0, 0, 0, 1, 1, 0);
        read_at(4'd1, v);
        chk("R5 end record", 32'(v), 32'({1'b0, 2'd1, 2'd2, 4'h9, 1'b1, 2'd2, 3'd0}));
        step("R5 ack with nothing open", 0, 0, 0, 0, 0, 0, 1, 1, 0);
    endtask

    task automatic t_same_cycle;
        logic [14:0] v;
        step("R4 start m0", 1, 0, 1, 16'h1234, 0, 1, 0, 0, 0);
        step("R6 start m2 end m0", 1, 2, 3, 16'hF00F, 1, 3, 1, 0, 0);
        read_at(4'd3, v);
        chk("R6 start in lower slot", 32'(v), 32'({1'b1, 2'd2, 2'd3, 4'h0, 1'b1, 2'd3, 3'd2}));
        read_at(4'd4, v);
        chk("R6 end in upper slot", 32'(v), 32'({1'b0, 2'd0, 2'd1, 4'h4, 1'b0, 2'd1, 3'd1}));
        step("R6 same master end and restart", 1, 2, 0, 16'h0005, 0, 0, 1, 2, 0);
        step("R6 re-opened transaction closes", 0, 0, 0, 0, 0, 0, 1, 2, 0);
        read_at(4'd7, v);
        chk("R4 tag of re-opened transaction", 32'(v[2:0]), 32'd3);
        check_ring("R6 readout");
    endtask

    task automatic t_freeze;
        logic [14:0] v;
        step("R9 start while frozen", 1, 3, 1, 16'hABCD, 1, 0, 0, 0, 1);
        read_at(4'd7, v);
        chk("R9 contents kept", 32'(v), 32'(hist[7]));
        @(negedge clk); freeze_i = 1'b0;
        step("R9 end after unfreeze", 0, 0, 0, 0, 0, 0, 1, 3, 0);
        read_at(4'd8, v);
        chk("R4 tag advanced while frozen", 32'(v[2:0]), 32'd4);
    endtask

    task automatic t_wrap;
        logic [14:0] v;
        for (int k = 0; k < 5; k++) begin
            step("R7 fill start", 1, 0, 2'(k), 16'(k * 37), 1'(k), 2'(k), 0, 0, 0);
            step("R7 fill end", 0, 0, 0, 0, 0, 0, 1, 0, 0);
        end
        chk("R7 total written", 32'(total), 32'd19);
        read_at(4'd0, v);
        chk("R8 oldest after wrap", 32'(v), 32'(hist[3]));
        check_ring("R8 readout after wrap");
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_start_end();
        t_same_cycle();
        t_freeze();
        t_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule